// File: doc/BRIEF.md
# Progressive Raster Timing Generator

This block produces the scan timing for a progressive video frame. A pixel counter and a line counter walk the raster. From their positions the block decodes two groups of timing flags. The video-side group holds the active window, a horizontal sync window and a vertical sync window. The link-side group feeds the display transmitter: a data-enable, a horizontal sync and a vertical sync.

The link-side horizontal windows lag the video-side ones by a fixed pipeline latency, `LINK_LAG` pixels (default 2). The lag wraps around the end of the line. On both sides the vertical sync edges fall at fixed pixel positions inside the boundary lines. On the link side each sync output has its own polarity bit.

Software or a mode controller drives the per-axis geometry inputs: sync length, back porch length, active length and total length. The block samples them, together with the two polarity bits, at reset and at every frame boundary. A frame therefore never mixes two geometries. Every output is a register, and all outputs in one cycle describe the same raster position, the one shown on `pix_cnt`/`line_cnt`.

Top module: `raster_timing_gen`

## Requirements
- R1: `pix_cnt` counts 0 up to horizontal total − 1 and then returns to 0. `line_cnt` advances by one only when `pix_cnt` wraps, and it returns to 0 after line vertical total − 1.
- R2: `vid_hsync` is high exactly for pixels 0 to sync length − 1 of every line.
- R3: `vid_active` is high when both of these hold. First, the pixel lies in [hs + hbp, hs + hbp + active width). Second, the line lies in [vs + vbp, vs + vbp + active height). All end bounds are exclusive.
- R4: Treat raster position (line, pixel) in lexicographic order. `vid_vsync` is high from position (0, 16) up to, but not including, position (vertical sync length, 32).
- R5: Let q = (pixel − 2) mod horizontal total. `lnk_de` is high when q lies in the R3 horizontal window and the line lies in the R3 vertical window. With a late active window, the DE therefore wraps into pixels 0 and 1 of the same line.
- R6: Before polarity, the link horizontal sync is true when q (as in R5) is less than the horizontal sync length.
- R7: Before polarity, the link vertical sync is true from position (0, 2) up to, but not including, position (vertical sync length, 2).
- R8: When a polarity bit is 1, its link sync output equals the raw sync. When the bit is 0, the output is the raw sync inverted.
- R9: Geometry and polarity inputs changed mid-frame have no effect on any output until the counters return to (0, 0). From that frame on, the new values apply.
- R10: While reset is held, the counters read 0. All flags then show position (0, 0) under the geometry present at the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| h_sync_len | input | CW | Horizontal sync length in pixels (≥ 1) |
| h_back_len | input | CW | Horizontal back porch in pixels |
| h_active_len | input | CW | Active pixels per line |
| h_total_len | input | CW | Pixels per line (> 32) |
| v_sync_len | input | CW | Vertical sync length in lines (≥ 1) |
| v_back_len | input | CW | Vertical back porch in lines |
| v_active_len | input | CW | Active lines per frame |
| v_total_len | input | CW | Lines per frame |
| hs_pol_high | input | 1 | 1: link horizontal sync active high |
| vs_pol_high | input | 1 | 1: link vertical sync active high |
| pix_cnt | output | CW | Current pixel position |
| line_cnt | output | CW | Current line position |
| vid_active | output | 1 | Video-side active window |
| vid_hsync | output | 1 | Video-side horizontal sync window |
| vid_vsync | output | 1 | Video-side vertical sync window |
| lnk_de | output | 1 | Link-side data enable |
| lnk_hsync | output | 1 | Link-side horizontal sync after polarity |
| lnk_vsync | output | 1 | Link-side vertical sync after polarity |

## Verification
Some properties hold on every cycle, and the assertions check those:
- the pixel counter stays below the latched total;
- the line counter holds still except at a pixel wrap;
- the latched geometry does not move mid-frame;
- the active window never overlaps the horizontal sync;
- a link DE seen at pixel two or later was preceded by video activity two pixels earlier.

The exact window edges need the bench's full-frame sweeps, with positions computed arithmetically. These cover the wrapped link DE, the lexicographic vertical sync spans with their fixed pixel offsets, the polarity inversion, and the deferral of a geometry change to the next frame boundary.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

  // Default pipeline lag between video-side and link-side horizontal timing
  localparam int RTG_LINK_LAG   = 2;
  // Fixed pixel offsets of the video-side vertical sync edges
  localparam int RTG_VS_VID_BEG = 16;
  localparam int RTG_VS_VID_END = 32;

  // Decoded window flags for one raster position
  typedef struct packed {
    logic hsync;
    logic act_h;
    logic vsync;
    logic act_v;
  } rtg_win_t;

endpackage

// File: rtl/rtg_cfg_hold.sv
module rtg_cfg_hold #(
  parameter int W = 98
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] shadow_q,
  output logic [W-1:0] eff
);

  // Geometry is captured at reset and at each frame boundary (load covers both)
  always_ff @(posedge clk) begin
    if (load) shadow_q <= din;
  end

  // Bypass so that decode of the first position of a new frame sees new values
  assign eff = load ? din : shadow_q;

  // R9: latched geometry never moves inside a frame
  assert_hold_mid_frame_R9: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(shadow_q));

endmodule

// File: rtl/rtg_scan_counter.sv
module rtg_scan_counter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] tot_h,
  input  logic [CW-1:0] tot_v,
  output logic [CW-1:0] pix_q,
  output logic [CW-1:0] line_q,
  output logic [CW-1:0] pix_nx,
  output logic [CW-1:0] line_nx,
  output logic          frame_end
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic last_pix;
  logic last_line;

  assign last_pix  = (pix_q == tot_h - ONE);
  assign last_line = (line_q == tot_v - ONE);
  assign frame_end = last_pix && last_line;

  always_comb begin
    if (rst) begin
      pix_nx  = '0;
      line_nx = '0;
    end else if (last_pix) begin
      pix_nx  = '0;
      line_nx = last_line ? '0 : line_q + ONE;
    end else begin
      pix_nx  = pix_q + ONE;
      line_nx = line_q;
    end
  end

  always_ff @(posedge clk) begin
    pix_q  <= pix_nx;
    line_q <= line_nx;
  end

  // R1: pixel position stays inside the latched line length
  assert_pix_below_total_R1: assert property (@(posedge clk) disable iff (rst)
    pix_q < tot_h);

  // R1: line position only moves when the pixel position wraps
  assert_line_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (pix_q != tot_h - ONE) |=> (line_q == $past(line_q)));

endmodule

// File: rtl/rtg_window_dec.sv
module rtg_window_dec
  import rtg_pkg::*;
#(
  parameter int CW     = 12,
  parameter int LAG    = 0,
  parameter int VS_BEG = 16,
  parameter int VS_END = 32
) (
  input  logic [CW-1:0] pix,
  input  logic [CW-1:0] line,
  input  logic [CW-1:0] h_sw,
  input  logic [CW-1:0] h_bp,
  input  logic [CW-1:0] h_act,
  input  logic [CW-1:0] h_tot,
  input  logic [CW-1:0] v_sw,
  input  logic [CW-1:0] v_bp,
  input  logic [CW-1:0] v_act,
  output rtg_win_t      win
);

  localparam int SW = CW + 2;
  localparam logic [CW-1:0] LAG_V = CW'(LAG);
  localparam logic [CW-1:0] VSB_V = CW'(VS_BEG);
  localparam logic [CW-1:0] VSE_V = CW'(VS_END);

  // Horizontal index as seen through the lag, wrapped modulo the line length
  logic [CW-1:0] q;
  generate
    if (LAG == 0) begin : g_no_lag
      assign q = pix;
    end else begin : g_lag
      assign q = (pix >= LAG_V) ? (pix - LAG_V) : (pix + h_tot - LAG_V);
    end
  endgenerate

  logic [SW-1:0] q_x, line_x;
  logic [SW-1:0] h_beg, h_end, v_beg, v_end;

  assign q_x    = {2'b00, q};
  assign line_x = {2'b00, line};
  assign h_beg  = {2'b00, h_sw} + {2'b00, h_bp};
  assign h_end  = h_beg + {2'b00, h_act};
  assign v_beg  = {2'b00, v_sw} + {2'b00, v_bp};
  assign v_end  = v_beg + {2'b00, v_act};

  logic vs_after_beg, vs_before_end;
  assign vs_after_beg  = (line != '0) || (pix >= VSB_V);
  assign vs_before_end = (line < v_sw) || ((line == v_sw) && (pix < VSE_V));

  assign win.hsync = (q < h_sw);
  assign win.act_h = (q_x >= h_beg) && (q_x < h_end);
  assign win.act_v = (line_x >= v_beg) && (line_x < v_end);
  assign win.vsync = vs_after_beg && vs_before_end;

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int CW         = 12,
  parameter int LINK_LAG   = RTG_LINK_LAG,
  parameter int VS_VID_BEG = RTG_VS_VID_BEG,
  parameter int VS_VID_END = RTG_VS_VID_END
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] h_sync_len,
  input  logic [CW-1:0] h_back_len,
  input  logic [CW-1:0] h_active_len,
  input  logic [CW-1:0] h_total_len,
  input  logic [CW-1:0] v_sync_len,
  input  logic [CW-1:0] v_back_len,
  input  logic [CW-1:0] v_active_len,
  input  logic [CW-1:0] v_total_len,
  input  logic          hs_pol_high,
  input  logic          vs_pol_high,
  output logic [CW-1:0] pix_cnt,
  output logic [CW-1:0] line_cnt,
  output logic          vid_active,
  output logic          vid_hsync,
  output logic          vid_vsync,
  output logic          lnk_de,
  output logic          lnk_hsync,
  output logic          lnk_vsync
);

  localparam int CFG_W   = 8 * CW + 2;
  localparam int F_HSW   = 0 * CW;
  localparam int F_HBP   = 1 * CW;
  localparam int F_HACT  = 2 * CW;
  localparam int F_HTOT  = 3 * CW;
  localparam int F_VSW   = 4 * CW;
  localparam int F_VBP   = 5 * CW;
  localparam int F_VACT  = 6 * CW;
  localparam int F_VTOT  = 7 * CW;
  localparam int F_HPOL  = 8 * CW;
  localparam int F_VPOL  = 8 * CW + 1;

  logic [CFG_W-1:0] cfg_in, cfg_sh, cfg_eff;
  logic             frame_end, load;
  logic [CW-1:0]    pix_nx, line_nx;
  rtg_win_t         win_vid, win_lnk;

  assign cfg_in = {vs_pol_high, hs_pol_high,
                   v_total_len, v_active_len, v_back_len, v_sync_len,
                   h_total_len, h_active_len, h_back_len, h_sync_len};

  assign load = rst || frame_end;

  rtg_cfg_hold #(.W(CFG_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .din      (cfg_in),
    .shadow_q (cfg_sh),
    .eff      (cfg_eff)
  );

  rtg_scan_counter #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tot_h     (cfg_sh[F_HTOT +: CW]),
    .tot_v     (cfg_sh[F_VTOT +: CW]),
    .pix_q     (pix_cnt),
    .line_q    (line_cnt),
    .pix_nx    (pix_nx),
    .line_nx   (line_nx),
    .frame_end (frame_end)
  );

  // Two decoders: video side (no lag) and link side (lagged)
  rtg_window_dec #(.CW(CW), .LAG(0), .VS_BEG(VS_VID_BEG), .VS_END(VS_VID_END)) u_dec_vid (
    .pix   (pix_nx),
    .line  (line_nx),
    .h_sw  (cfg_eff[F_HSW +: CW]),
    .h_bp  (cfg_eff[F_HBP +: CW]),
    .h_act (cfg_eff[F_HACT +: CW]),
    .h_tot (cfg_eff[F_HTOT +: CW]),
    .v_sw  (cfg_eff[F_VSW +: CW]),
    .v_bp  (cfg_eff[F_VBP +: CW]),
    .v_act (cfg_eff[F_VACT +: CW]),
    .win   (win_vid)
  );

  rtg_window_dec #(.CW(CW), .LAG(LINK_LAG), .VS_BEG(LINK_LAG), .VS_END(LINK_LAG)) u_dec_lnk (
    .pix   (pix_nx),
    .line  (line_nx),
    .h_sw  (cfg_eff[F_HSW +: CW]),
    .h_bp  (cfg_eff[F_HBP +: CW]),
    .h_act (cfg_eff[F_HACT +: CW]),
    .h_tot (cfg_eff[F_HTOT +: CW]),
    .v_sw  (cfg_eff[F_VSW +: CW]),
    .v_bp  (cfg_eff[F_VBP +: CW]),
    .v_act (cfg_eff[F_VACT +: CW]),
    .win   (win_lnk)
  );

  // Output registers, aligned with the counter registers
  always_ff @(posedge clk) begin
    vid_active <= win_vid.act_h && win_vid.act_v;
    vid_hsync  <= win_vid.hsync;
    vid_vsync  <= win_vid.vsync;
    lnk_de     <= win_lnk.act_h && win_lnk.act_v;
    lnk_hsync  <= cfg_eff[F_HPOL] ? win_lnk.hsync : !win_lnk.hsync;
    lnk_vsync  <= cfg_eff[F_VPOL] ? win_lnk.vsync : !win_lnk.vsync;
  end

  // R3: active window begins only after the horizontal sync has ended
  assert_active_clear_of_sync_R3: assert property (@(posedge clk) disable iff (rst)
    vid_active |-> !vid_hsync);

  // R5: a link DE away from the line start follows video activity by the lag
  generate
    if (LINK_LAG == 2) begin : g_lag_chk
      assert_de_follows_video_R5: assert property (@(posedge clk) disable iff (rst)
        (lnk_de && (pix_cnt >= CW'(2))) |-> $past(vid_active, 2));
    end
  endgenerate

endmodule

// File: tb/raster_timing_gen_tb_top.sv
module raster_timing_gen_tb_top;

  localparam int CW  = 12;
  localparam int LAG = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int h_sw = 4, h_bp = 5, h_act = 20, h_tot = 40;
  int v_sw = 2, v_bp = 3, v_act = 6,  v_tot = 14;
  bit hp = 1'b1, vp = 1'b1;

  logic [CW-1:0] pix_cnt, line_cnt;
  logic vid_active, vid_hsync, vid_vsync, lnk_de, lnk_hsync, lnk_vsync;

  raster_timing_gen #(.CW(CW)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .h_sync_len   (CW'(h_sw)),
    .h_back_len   (CW'(h_bp)),
    .h_active_len (CW'(h_act)),
    .h_total_len  (CW'(h_tot)),
    .v_sync_len   (CW'(v_sw)),
    .v_back_len   (CW'(v_bp)),
    .v_active_len (CW'(v_act)),
    .v_total_len  (CW'(v_tot)),
    .hs_pol_high  (hp),
    .vs_pol_high  (vp),
    .pix_cnt      (pix_cnt),
    .line_cnt     (line_cnt),
    .vid_active   (vid_active),
    .vid_hsync    (vid_hsync),
    .vid_vsync    (vid_vsync),
    .lnk_de       (lnk_de),
    .lnk_hsync    (lnk_hsync),
    .lnk_vsync    (lnk_vsync)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit pending = 1'b0;

  // Model state: latched geometry and position
  int m_sw, m_bp, m_act, m_tot, m_vsw, m_vbp, m_vact, m_vtot;
  bit m_hp, m_vp;
  int mp, ml;

  task automatic latch_model;
    m_sw = h_sw; m_bp = h_bp; m_act = h_act; m_tot = h_tot;
    m_vsw = v_sw; m_vbp = v_bp; m_vact = v_act; m_vtot = v_tot;
    m_hp = hp; m_vp = vp;
    pending = 1'b0;
  endtask

  task automatic step_model;
    if (mp == m_tot - 1) begin
      mp = 0;
      if (ml == m_vtot - 1) begin
        ml = 0;
        latch_model();
      end else begin
        ml = ml + 1;
      end
    end else begin
      mp = mp + 1;
    end
  endtask

  task automatic chk(input int act, input int exp, input string req, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s at (line %0d, pix %0d): got %0d expected %0d",
               req, what, ml, mp, act, exp);
    end
  endtask

  task automatic check_all(input string ctr_req);
    int  q, pos;
    bit  v_in, h_in, q_in, s;
    q    = (mp + m_tot - LAG) % m_tot;
    pos  = ml * m_tot + mp;
    v_in = (ml >= m_vsw + m_vbp) && (ml < m_vsw + m_vbp + m_vact);
    h_in = (mp >= m_sw + m_bp) && (mp < m_sw + m_bp + m_act);
    q_in = (q  >= m_sw + m_bp) && (q  < m_sw + m_bp + m_act);
    chk(int'(pix_cnt),  mp, ctr_req, "pix_cnt");
    chk(int'(line_cnt), ml, ctr_req, "line_cnt");
    chk(int'(vid_hsync), int'(mp < m_sw), pending ? "R9" : "R2", "vid_hsync");
    chk(int'(vid_active), int'(h_in && v_in), "R3", "vid_active");
    chk(int'(vid_vsync), int'(pos >= 16 && pos < m_vsw * m_tot + 32), "R4", "vid_vsync");
    chk(int'(lnk_de), int'(q_in && v_in), "R5", "lnk_de");
    s = (q < m_sw);
    chk(int'(lnk_hsync), int'(s == m_hp), m_hp ? "R6" : "R8", "lnk_hsync");
    s = (pos >= LAG) && (pos < m_vsw * m_tot + LAG);
    chk(int'(lnk_vsync), int'(s == m_vp), m_vp ? "R7" : "R8", "lnk_vsync");
  endtask

  task automatic do_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    mp = 0; ml = 0;
    latch_model();
    check_all("R10");   // R10: reset state at position (0,0)
    rst = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      step_model();
      check_all(pending ? "R9" : "R1");
    end
  endtask

  task automatic set_cfg(input int a, input int b, input int c, input int d,
                         input int e, input int f, input int g, input int h,
                         input bit php, input bit pvp);
    h_sw = a; h_bp = b; h_act = c; h_tot = d;
    v_sw = e; v_bp = f; v_act = g; v_tot = h;
    hp = php; vp = pvp;
    pending = 1'b1;     // R9: must not apply before the next frame start
  endtask

  initial begin
    // Config A, both polarities high: two full frames
    do_reset();
    run(1120);
    // Mid-frame switch to config B, both polarities low
    run(250);
    set_cfg(3, 4, 32, 40, 1, 2, 8, 12, 1'b0, 1'b0);
    run(1400);
    // Mid-frame switch to config C: active wraps through the link lag
    run(37);
    set_cfg(1, 0, 39, 40, 1, 0, 13, 14, 1'b1, 1'b0);
    run(1300);
    // Config D taken directly by a reset in mid-frame
    run(123);
    set_cfg(6, 2, 24, 48, 3, 1, 5, 12, 1'b0, 1'b1);
    do_reset();
    run(1200);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, got 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule